// File: doc/BRIEF.md
# Dual-Strobe Up/Down Counter with Cascade Outputs

A four-stage counter whose direction is chosen by which of two strobe lines rises: a rising edge on the up strobe (while the down strobe rests high) adds one, and a rising edge on the down strobe (while the up strobe rests high) subtracts one. A parameter picks decade counting (0 to 9) or plain binary counting (0 to 15). An active-high clear empties the counter and an active-low load copies four data bits into it. Both act at once, without waiting for any clock.

Both strobes are sampled by one system clock through a two-flop synchronizer, and the edges are found in logic. Two active-low outputs, an overflow flag and an underflow flag, follow the strobe that caused them. Wiring the overflow flag to the next stage's up strobe and the underflow flag to its down strobe chains stages into a wider counter. Each strobe level must be held for at least three system clocks.

Top module: `updn_counter`

## Requirements
- R1: A rising up strobe while the down strobe is high adds one to the count; the new value appears on the second clock edge after the synchronized edge is seen.
- R2: A rising down strobe while the up strobe is high subtracts one from the count.
- R3: While clear is high the count is 0 at once, whatever the strobes do.
- R4: Clear wins over load: with both active the count stays 0.
- R5: With clear low, a low load copies dataIn into the count at once, whatever the strobes do.
- R6: With DECADE=1 the count goes from 9 to 0 when counting up and from 0 to 9 when counting down.
- R7: With DECADE=0 the count goes from 15 to 0 when counting up and from 0 to 15 when counting down.
- R8: carryN is low only while the count is at its top value (9 decade, 15 binary) and the synchronized up strobe is low; its return high comes with the wrap to 0.
- R9: borrowN is low only while the count is 0 and the synchronized down strobe is low; its return high comes with the wrap to the top value.
- R10: If both strobes are low at the same time and then rise in the same sample, the count holds.
- R11: With DECADE=1, a loaded value from 10 to 15 steps as in binary: 15 goes up to 0, and 12 goes down to 11.
- R12: Two stages chained carryN to upStrobe and borrowN to downStrobe count as one two-digit counter in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the strobes |
| rstN | input | 1 | Active-low reset of the strobe synchronizers |
| upStrobe | input | 1 | A rising edge counts up |
| downStrobe | input | 1 | A rising edge counts down |
| clear | input | 1 | Active-high asynchronous clear |
| loadN | input | 1 | Active-low asynchronous parallel load |
| dataIn | input | WIDTH | Value taken by load |
| count | output | WIDTH | Current count |
| carryN | output | 1 | Active-low overflow flag for cascading |
| borrowN | output | 1 | Active-low underflow flag for cascading |

## Verification
The embedded assertions check on every clock that single steps land one above or one below the previous value. They also check that the wrap lands on the right value, that clear and load hold the count where they should, that simultaneous strobe edges leave the count alone, and that the carry and borrow flags are never low away from the top value or zero. The bench's scenarios are needed to show the asynchronous action of clear and load between clock edges, the true two-digit behaviour of a chained pair across the 9 to 0 and 0 to 9 boundaries, the binary variant, and the stepping of out-of-range decade values.

// File: rtl/updn_pkg.sv
package updn_pkg;
  // Synchronized strobe information handed from control to datapath
  typedef struct packed {
    logic upRise;
    logic dnRise;
    logic upLvl;
    logic dnLvl;
  } strobeEvt_t;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync
  import updn_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       upIn,
  input  logic       dnIn,
  output strobeEvt_t evt
);
  // Per channel: STAGES synchronizer flops plus one history flop
  localparam int DEPTH = STAGES + 1;
  localparam int NCHAN = 2;

  logic [NCHAN-1:0] rawIn;
  logic [NCHAN-1:0] lvl;
  logic [NCHAN-1:0] rise;

  assign rawIn = {dnIn, upIn};

  for (genvar ch = 0; ch < NCHAN; ch++) begin : gChan
    logic [DEPTH-1:0] pipe;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe <= '1;
      else       pipe <= {pipe[DEPTH-2:0], rawIn[ch]};
    end
    assign lvl[ch]  = pipe[STAGES-1];
    assign rise[ch] = pipe[STAGES-1] & ~pipe[STAGES];
  end

  always_comb begin
    evt.upRise = rise[0];
    evt.dnRise = rise[1];
    evt.upLvl  = lvl[0];
    evt.dnLvl  = lvl[1];
  end

  // R10: a rise is a single-sample event on each channel
  assert_rise_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    evt.upRise |=> !evt.upRise);
  assert_rise_single_dn_R10: assert property (@(posedge clk) disable iff (!rstN)
    evt.dnRise |=> !evt.dnRise);
endmodule

// File: rtl/count_path.sv
module count_path
  import updn_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeEvt_t       evt,
  input  logic             clear,
  input  logic             loadN,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] cnt,
  output logic             carryN,
  output logic             borrowN
);
  localparam logic [WIDTH-1:0] TOP_VAL = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ALL_ONE = {WIDTH{1'b1}};

  logic goUp, goDn;
  logic [WIDTH-1:0] nxt;

  always_comb begin
    goUp = evt.upRise && evt.dnLvl && !evt.dnRise;
    goDn = evt.dnRise && evt.upLvl && !evt.upRise;
    nxt  = cnt;
    if (goUp)      nxt = (cnt == TOP_VAL) ? '0 : cnt + 1'b1;
    else if (goDn) nxt = (cnt == '0) ? TOP_VAL : cnt - 1'b1;
  end

  always_ff @(posedge clk or posedge clear or negedge loadN) begin
    if (clear)       cnt <= '0;
    else if (!loadN) cnt <= dataIn;
    else             cnt <= nxt;
  end

  assign carryN  = !((cnt == TOP_VAL) && !evt.upLvl);
  assign borrowN = !((cnt == '0) && !evt.dnLvl);

  // R1: plain up step
  assert_up_step_R1: assert property (@(posedge clk) disable iff (!rstN || clear || !loadN)
    (evt.upRise && evt.dnLvl && !evt.dnRise && cnt != TOP_VAL && cnt != ALL_ONE)
    |=> cnt == $past(cnt) + WIDTH'(1));
  // R2: plain down step
  assert_down_step_R2: assert property (@(posedge clk) disable iff (!rstN || clear || !loadN)
    (evt.dnRise && evt.upLvl && !evt.upRise && cnt != '0)
    |=> cnt == $past(cnt) - WIDTH'(1));
  // R6 / R7: wrap values
  assert_wrap_up_R6: assert property (@(posedge clk) disable iff (!rstN || clear || !loadN)
    (evt.upRise && evt.dnLvl && !evt.dnRise && cnt == TOP_VAL) |=> cnt == '0);
  assert_wrap_down_R7: assert property (@(posedge clk) disable iff (!rstN || clear || !loadN)
    (evt.dnRise && evt.upLvl && !evt.upRise && cnt == '0) |=> cnt == TOP_VAL);
  // R10: simultaneous edges hold the count
  assert_hold_both_R10: assert property (@(posedge clk) disable iff (!rstN || clear || !loadN)
    (evt.upRise && evt.dnRise) |=> $stable(cnt));
  // R3 / R4: clear forces zero, also over load
  assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    clear |-> cnt == '0);
  // R5: load holds the data value
  assert_load_copy_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!loadN && !clear) |-> cnt == dataIn);
endmodule

// File: rtl/updn_counter.sv
module updn_counter
  import updn_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter bit DECADE      = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             upStrobe,
  input  logic             downStrobe,
  input  logic             clear,
  input  logic             loadN,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] count,
  output logic             carryN,
  output logic             borrowN
);
  localparam logic [WIDTH-1:0] TOP_VAL = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};

  strobeEvt_t evt;

  strobe_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .upIn (upStrobe),
    .dnIn (downStrobe),
    .evt  (evt)
  );

  count_path #(.WIDTH(WIDTH), .DECADE(DECADE)) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .evt     (evt),
    .clear   (clear),
    .loadN   (loadN),
    .dataIn  (dataIn),
    .cnt     (count),
    .carryN  (carryN),
    .borrowN (borrowN)
  );

  // R8: carry low only at the top value
  assert_carry_at_top_R8: assert property (@(posedge clk) disable iff (!rstN)
    !carryN |-> count == TOP_VAL);
  // R9: borrow low only at zero
  assert_borrow_at_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    !borrowN |-> count == '0);
endmodule

// File: tb/tb_updn_counter.sv
module tb_updn_counter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic upS = 1'b1, dnS = 1'b1, clr = 1'b1;
  logic ldLo = 1'b1, ldHi = 1'b1, ldBin = 1'b1;
  logic binUp = 1'b1, binDn = 1'b1;
  logic [3:0] dLo = '0, dHi = '0, dBin = '0;
  logic [3:0] qLo, qHi, qBin;
  logic carryLo, borrowLo, carryHi, borrowHi, carryBin, borrowBin;

  int applied = 0;
  int miscompares = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  updn_counter #(.DECADE(1'b1)) dut (
    .clk(clk), .rstN(rstN), .upStrobe(upS), .downStrobe(dnS), .clear(clr),
    .loadN(ldLo), .dataIn(dLo), .count(qLo), .carryN(carryLo), .borrowN(borrowLo));

  updn_counter #(.DECADE(1'b1)) dutHi (
    .clk(clk), .rstN(rstN), .upStrobe(carryLo), .downStrobe(borrowLo), .clear(clr),
    .loadN(ldHi), .dataIn(dHi), .count(qHi), .carryN(carryHi), .borrowN(borrowHi));

  updn_counter #(.DECADE(1'b0)) dutBin (
    .clk(clk), .rstN(rstN), .upStrobe(binUp), .downStrobe(binDn), .clear(clr),
    .loadN(ldBin), .dataIn(dBin), .count(qBin), .carryN(carryBin), .borrowN(borrowBin));

  task automatic chk(input string req, input int act, input int exp);
    applied++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // which: 0 low-stage up, 1 low-stage down, 2 binary up, 3 binary down
  task automatic pulse(input int which);
    case (which)
      0: upS = 1'b0;  1: dnS = 1'b0;
      2: binUp = 1'b0; default: binDn = 1'b0;
    endcase
    waitClk(4);
    case (which)
      0: upS = 1'b1;  1: dnS = 1'b1;
      2: binUp = 1'b1; default: binDn = 1'b1;
    endcase
    waitClk(8);
  endtask

  task automatic loadLo(input logic [3:0] v);
    dLo = v; #1; ldLo = 1'b0; #1;
    chk("R5 async load", int'(qLo), int'(v));
    #1; ldLo = 1'b1; #1;
  endtask

  task automatic loadHi(input logic [3:0] v);
    dHi = v; #1; ldHi = 1'b0; #2; ldHi = 1'b1; #1;
  endtask

  task automatic loadBin(input logic [3:0] v);
    dBin = v; #1; ldBin = 1'b0; #2; ldBin = 1'b1; #1;
  endtask

  task automatic tReset();
    chk("R3 reset count lo", int'(qLo), 0);
    chk("R3 reset count hi", int'(qHi), 0);
    chk("R8 reset carry high", int'(carryLo), 1);
    chk("R9 reset borrow high", int'(borrowLo), 1);
  endtask

  task automatic tCountUp();
    loadHi(4'd0);
    loadLo(4'd3);
    pulse(0); pulse(0);
    chk("R1 two up steps", int'(qLo), 5);
  endtask

  task automatic tCountDown();
    pulse(1);
    chk("R2 one down step", int'(qLo), 4);
  endtask

  task automatic tDecadeUp();
    loadHi(4'd2);
    loadLo(4'd9);
    chk("R8 carry high while up strobe high", int'(carryLo), 1);
    upS = 1'b0; waitClk(4);
    chk("R8 carry low at 9 with up low", int'(carryLo), 0);
    chk("R12 upper stage waits", int'(qHi), 2);
    upS = 1'b1; waitClk(8);
    chk("R6 decade wrap up", int'(qLo), 0);
    chk("R8 carry released", int'(carryLo), 1);
    chk("R12 upper stage up", int'(qHi), 3);
  endtask

  task automatic tDecadeDown();
    dnS = 1'b0; waitClk(4);
    chk("R9 borrow low at 0 with down low", int'(borrowLo), 0);
    dnS = 1'b1; waitClk(8);
    chk("R6 decade wrap down", int'(qLo), 9);
    chk("R9 borrow released", int'(borrowLo), 1);
    chk("R12 upper stage down", int'(qHi), 2);
  endtask

  task automatic tBinary();
    loadBin(4'd15);
    binUp = 1'b0; waitClk(4);
    chk("R8 binary carry low at 15", int'(carryBin), 0);
    binUp = 1'b1; waitClk(8);
    chk("R7 binary wrap up", int'(qBin), 0);
    pulse(3);
    chk("R7 binary wrap down", int'(qBin), 15);
    pulse(3);
    chk("R7 binary step down", int'(qBin), 14);
  endtask

  task automatic tIllegal();
    loadLo(4'd5);
    upS = 1'b0; dnS = 1'b0; waitClk(4);
    upS = 1'b1; dnS = 1'b1; waitClk(8);
    chk("R10 both strobes hold", int'(qLo), 5);
  endtask

  task automatic tOutOfRange();
    loadHi(4'd1);
    loadLo(4'd15);
    pulse(0);
    chk("R11 decade 15 up gives 0", int'(qLo), 0);
    chk("R11 no carry from 15", int'(qHi), 1);
    loadLo(4'd12);
    pulse(1);
    chk("R11 decade 12 down gives 11", int'(qLo), 11);
  endtask

  task automatic tClear();
    loadLo(4'd7);
    clr = 1'b1; #1;
    chk("R3 async clear", int'(qLo), 0);
    dLo = 4'd6; ldLo = 1'b0; #1;
    chk("R4 clear over load", int'(qLo), 0);
    ldLo = 1'b1;
    pulse(0);
    chk("R3 strobe ignored during clear", int'(qLo), 0);
    clr = 1'b0; waitClk(2);
    chk("R3 zero after clear drops", int'(qLo), 0);
  endtask

  initial begin
    waitClk(3);
    rstN = 1'b1;
    waitClk(2);
    tReset();
    clr = 1'b0;
    waitClk(2);
    tCountUp();
    tCountDown();
    tDecadeUp();
    tDecadeDown();
    tBinary();
    tIllegal();
    tOutOfRange();
    tClear();
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    applied++;
    miscompares++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule